// File: doc/BRIEF.md
# Store-Behind Dirty Page Writeback Controller

This block manages writes and evictions for one level of a multi-level page store. The level sits between a faster neighbour above and slower neighbours below. Each resident page slot carries a changed flag. Processor writes land only in this level and mark the slot changed. Reads and writes from above, together with fills arriving from below, are the foreground traffic. Any cycle in which none of them occupies the level may be used to copy a changed page down, so that slots become clean again and can be replaced without a transfer.

In the default store-behind policy, a copy is started only when the number of clean slots falls below a configured minimum. A changed page stays resident, and its flag stays set, until the level directly below acknowledges the copy. A stricter option also waits for the level two steps down. An alternative store-on-evict policy makes no idle copies at all. Instead, when a fill finds no clean slot, the lowest changed slot is copied down and the fill stalls until that copy is acknowledged.

A fill always lands in the lowest-numbered clean slot. It never overwrites changed data that has not been acknowledged. The three configuration inputs are captured only while reset is held.

Top module: `store_behind_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it is released, every slot is clean and `wb_valid`, `fill_ack` and `rd_resp_valid` are 0. After reset, the first fill is placed in slot 0.
- R2: A processor write stores its data in the named slot and sets that slot's changed flag. A read returns the slot's data with `rd_resp_valid` high exactly one cycle after the request.
- R3: A fill that can be served is written into the lowest-numbered clean slot. `fill_ack` is then pulsed for one cycle, with `fill_slot` naming that slot. Serving a fill causes no writeback.
- R4: A writeback starts only in a cycle with no read request and no write request. In the store-behind policy, that cycle must also have no fill that can be served. The `wb_valid` pulse follows one cycle later and carries the lowest-numbered changed slot that is not already being copied, together with that slot's data.
- R5: In the store-behind policy, a writeback starts only while the clean-slot count is below the captured threshold, with a threshold of 0 treated as 1. No writeback starts while the count is at or above the threshold.
- R6: At most one writeback is outstanding at a time. A slot's changed flag is cleared only by the required acknowledgement naming that slot. An acknowledgement that names any other slot has no effect.
- R7: With dual acknowledgement selected (`cfg_dual_ack`=1), the flag is cleared only after both the near and the far acknowledgement for the slot have arrived, in either order. With `cfg_dual_ack`=0, the near acknowledgement alone is enough.
- R8: A processor write to a slot while that slot's copy is outstanding keeps the flag set when the acknowledgement arrives. A later writeback then carries the newer data.
- R9: A fill that finds no clean slot waits, without `fill_ack`, until an acknowledgement makes a slot clean. It is then served into that slot.
- R10: With `cfg_evict_copy`=1 (store-on-evict), no idle writeback ever starts. A fill that finds no clean slot starts a writeback of the lowest changed slot and completes only after that copy is acknowledged.
- R11: `cfg_clean_min`, `cfg_dual_ack` and `cfg_evict_copy` are captured while `rst` is high. Changes to them after reset has been released have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; configuration is captured while high |
| cfg_clean_min | input | CW | Clean-slot threshold for idle writeback (0 acts as 1) |
| cfg_dual_ack | input | 1 | 1: require both near and far acknowledgements before clearing |
| cfg_evict_copy | input | 1 | 1: store-on-evict policy; 0: store-behind policy |
| up_rd_valid | input | 1 | Foreground read request |
| up_rd_slot | input | SW | Slot to read |
| up_wr_valid | input | 1 | Foreground processor write |
| up_wr_slot | input | SW | Slot to write |
| up_wr_data | input | DW | Write data |
| fill_req | input | 1 | Fill request from below, held until `fill_ack` |
| fill_data | input | DW | Page data for the fill |
| near_ack_valid | input | 1 | Acknowledgement from the next lower level |
| near_ack_slot | input | SW | Slot being acknowledged by the next lower level |
| far_ack_valid | input | 1 | Acknowledgement from the level two steps down |
| far_ack_slot | input | SW | Slot being acknowledged by the far level |
| rd_resp_valid | output | 1 | Read data valid |
| rd_resp_data | output | DW | Read data |
| wb_valid | output | 1 | Writeback pulse to the lower level |
| wb_slot | output | SW | Slot being written back |
| wb_data | output | DW | Page data being written back |
| fill_ack | output | 1 | Fill accepted |
| fill_slot | output | SW | Slot the fill was written into |

## Verification
The assertions assume that the lower levels acknowledge only copies that were actually sent, and that a fill request stays high with steady data until `fill_ack` is returned. They also assume that a read and a write never name the same slot in the same cycle. The bench respects these assumptions: it raises an acknowledgement only after it has seen the matching `wb_valid`, it holds `fill_req` until the acknowledging pulse and drops it in the very next half cycle, and it never reads a slot in the same cycle it writes it. Slot states are driven deliberately to the edge of the threshold, so that each idle cycle's expected writeback can be predicted exactly.

// File: rtl/sbc_pkg.sv
package sbc_pkg;
  // Writeback policy selected at reset.
  typedef enum logic {
    POL_BEHIND = 1'b0,   // copy changed pages during idle cycles
    POL_EVICT  = 1'b1    // copy a changed page only when a fill needs its slot
  } wb_policy_e;

  // Configuration captured while reset is held.
  typedef struct packed {
    logic       dual_ack;
    wb_policy_e policy;
  } sbc_mode_t;
endpackage

// File: rtl/sbc_page_ram.sv
module sbc_page_ram #(
  parameter int DEPTH = 8,
  parameter int DW    = 32,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  // Simple dual-port, registered read: maps onto block RAM.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/sbc_slot_table.sv
module sbc_slot_table #(
  parameter int NSLOT = 8,
  localparam int SW   = (NSLOT > 1) ? $clog2(NSLOT) : 1,
  localparam int CW   = $clog2(NSLOT + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_en,
  input  logic [SW-1:0]    set_idx,
  input  logic             clr_en,
  input  logic [SW-1:0]    clr_idx,
  input  logic [NSLOT-1:0] busy_mask,
  output logic [NSLOT-1:0] dirty,
  output logic [CW-1:0]    clean_cnt,
  output logic             clean_any,
  output logic [SW-1:0]    clean_idx,
  output logic             cand_any,
  output logic [SW-1:0]    cand_idx
);
  // One changed flag per slot; a write in the same cycle wins over a clear.
  for (genvar g = 0; g < NSLOT; g++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)
        dirty[g] <= 1'b0;
      else if (set_en && set_idx == SW'(g))
        dirty[g] <= 1'b1;
      else if (clr_en && clr_idx == SW'(g))
        dirty[g] <= 1'b0;
    end
  end

  // Clean population count.
  always_comb begin
    clean_cnt = '0;
    for (int i = 0; i < NSLOT; i++)
      clean_cnt = clean_cnt + {{(CW-1){1'b0}}, ~dirty[i]};
  end

  // Lowest-index clean slot (victim for fills).
  always_comb begin
    clean_any = 1'b0;
    clean_idx = '0;
    for (int i = NSLOT - 1; i >= 0; i--) begin
      if (!dirty[i]) begin
        clean_any = 1'b1;
        clean_idx = SW'(i);
      end
    end
  end

  // Lowest-index changed slot not already being copied.
  always_comb begin
    cand_any = 1'b0;
    cand_idx = '0;
    for (int i = NSLOT - 1; i >= 0; i--) begin
      if (dirty[i] && !busy_mask[i]) begin
        cand_any = 1'b1;
        cand_idx = SW'(i);
      end
    end
  end
endmodule

// File: rtl/sbc_ack_track.sv
module sbc_ack_track #(
  parameter int NSLOT = 8,
  localparam int SW   = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dual_ack,
  input  logic             issue_en,
  input  logic [SW-1:0]    issue_idx,
  input  logic             wr_en,
  input  logic [SW-1:0]    wr_idx,
  input  logic             near_valid,
  input  logic [SW-1:0]    near_slot,
  input  logic             far_valid,
  input  logic [SW-1:0]    far_slot,
  output logic             busy,
  output logic [SW-1:0]    cur_slot,
  output logic [NSLOT-1:0] busy_mask,
  output logic             clean_ok
);
  logic got_near, got_far, rewritten;
  logic near_hit, far_hit, near_n, far_n, retire;

  assign near_hit = near_valid && near_slot == cur_slot;
  assign far_hit  = far_valid  && far_slot  == cur_slot;
  assign near_n   = got_near || near_hit;
  assign far_n    = got_far  || far_hit;
  assign retire   = busy && near_n && (far_n || !dual_ack);
  // A write during the copy leaves the flag set; a write in the retire cycle
  // is covered by the slot table's set-over-clear priority.
  assign clean_ok = retire && !rewritten;

  always_comb begin
    busy_mask = '0;
    if (busy) busy_mask[cur_slot] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      cur_slot  <= '0;
      got_near  <= 1'b0;
      got_far   <= 1'b0;
      rewritten <= 1'b0;
    end else if (retire) begin
      busy <= 1'b0;
    end else if (issue_en) begin
      busy      <= 1'b1;
      cur_slot  <= issue_idx;
      got_near  <= 1'b0;
      got_far   <= 1'b0;
      rewritten <= 1'b0;
    end else if (busy) begin
      got_near  <= near_n;
      got_far   <= far_n;
      rewritten <= rewritten || (wr_en && wr_idx == cur_slot);
    end
  end
endmodule

// File: rtl/store_behind_ctrl.sv
module store_behind_ctrl #(
  parameter int NSLOT = 8,
  parameter int DW    = 32,
  localparam int SW   = (NSLOT > 1) ? $clog2(NSLOT) : 1,
  localparam int CW   = $clog2(NSLOT + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] cfg_clean_min,
  input  logic          cfg_dual_ack,
  input  logic          cfg_evict_copy,
  input  logic          up_rd_valid,
  input  logic [SW-1:0] up_rd_slot,
  input  logic          up_wr_valid,
  input  logic [SW-1:0] up_wr_slot,
  input  logic [DW-1:0] up_wr_data,
  input  logic          fill_req,
  input  logic [DW-1:0] fill_data,
  input  logic          near_ack_valid,
  input  logic [SW-1:0] near_ack_slot,
  input  logic          far_ack_valid,
  input  logic [SW-1:0] far_ack_slot,
  output logic          rd_resp_valid,
  output logic [DW-1:0] rd_resp_data,
  output logic          wb_valid,
  output logic [SW-1:0] wb_slot,
  output logic [DW-1:0] wb_data,
  output logic          fill_ack,
  output logic [SW-1:0] fill_slot
);
  import sbc_pkg::*;

  sbc_mode_t     mode_q;
  logic [CW-1:0] thr_q;

  // Configuration is captured only while reset is held.
  always_ff @(posedge clk) begin
    if (rst) begin
      thr_q           <= (cfg_clean_min == '0) ? CW'(1) : cfg_clean_min;
      mode_q.dual_ack <= cfg_dual_ack;
      mode_q.policy   <= cfg_evict_copy ? POL_EVICT : POL_BEHIND;
    end
  end

  logic [NSLOT-1:0] dirty_vec, busy_mask;
  logic [CW-1:0]    clean_cnt;
  logic             clean_any, cand_any;
  logic [SW-1:0]    clean_idx, cand_idx;
  logic             trk_busy, clean_ok;
  logic [SW-1:0]    trk_slot;
  logic             fill_go, fill_open, wb_issue, behind_ok, evict_ok;
  logic             ram_we;
  logic [SW-1:0]    ram_waddr, ram_raddr;
  logic [DW-1:0]    ram_wdata, ram_rdata;

  // A fill is open until acknowledged; it is served only when a clean slot
  // exists and the write port is not taken by a processor write.
  assign fill_open = fill_req && !fill_ack;
  assign fill_go   = fill_open && clean_any && !up_wr_valid;

  assign behind_ok = (mode_q.policy == POL_BEHIND) && !fill_go && (clean_cnt < thr_q);
  assign evict_ok  = (mode_q.policy == POL_EVICT) && fill_open && !clean_any;
  assign wb_issue  = !trk_busy && cand_any && !up_rd_valid && !up_wr_valid &&
                     (behind_ok || evict_ok);

  assign ram_we    = up_wr_valid || fill_go;
  assign ram_waddr = up_wr_valid ? up_wr_slot : clean_idx;
  assign ram_wdata = up_wr_valid ? up_wr_data : fill_data;
  assign ram_raddr = up_rd_valid ? up_rd_slot : cand_idx;

  sbc_page_ram #(.DEPTH(NSLOT), .DW(DW)) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .waddr (ram_waddr),
    .wdata (ram_wdata),
    .raddr (ram_raddr),
    .rdata (ram_rdata)
  );

  sbc_slot_table #(.NSLOT(NSLOT)) u_slots (
    .clk       (clk),
    .rst       (rst),
    .set_en    (up_wr_valid),
    .set_idx   (up_wr_slot),
    .clr_en    (clean_ok),
    .clr_idx   (trk_slot),
    .busy_mask (busy_mask),
    .dirty     (dirty_vec),
    .clean_cnt (clean_cnt),
    .clean_any (clean_any),
    .clean_idx (clean_idx),
    .cand_any  (cand_any),
    .cand_idx  (cand_idx)
  );

  sbc_ack_track #(.NSLOT(NSLOT)) u_track (
    .clk        (clk),
    .rst        (rst),
    .dual_ack   (mode_q.dual_ack),
    .issue_en   (wb_issue),
    .issue_idx  (cand_idx),
    .wr_en      (up_wr_valid),
    .wr_idx     (up_wr_slot),
    .near_valid (near_ack_valid),
    .near_slot  (near_ack_slot),
    .far_valid  (far_ack_valid),
    .far_slot   (far_ack_slot),
    .busy       (trk_busy),
    .cur_slot   (trk_slot),
    .busy_mask  (busy_mask),
    .clean_ok   (clean_ok)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_resp_valid <= 1'b0;
      wb_valid      <= 1'b0;
      wb_slot       <= '0;
      fill_ack      <= 1'b0;
      fill_slot     <= '0;
    end else begin
      rd_resp_valid <= up_rd_valid;
      wb_valid      <= wb_issue;
      if (wb_issue) wb_slot <= cand_idx;
      fill_ack      <= fill_go;
      if (fill_go) fill_slot <= clean_idx;
    end
  end

  assign rd_resp_data = ram_rdata;
  assign wb_data      = ram_rdata;
endmodule

// File: rtl/sbc_checker.sv
module sbc_checker #(
  parameter int NSLOT = 8,
  localparam int SW   = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
  input logic             clk,
  input logic             rst,
  input logic             up_rd_valid,
  input logic             up_wr_valid,
  input logic             rd_resp_valid,
  input logic             wb_valid,
  input logic             fill_ack,
  input logic [SW-1:0]    fill_slot,
  input logic             busy,
  input logic [SW-1:0]    cur_slot,
  input logic [NSLOT-1:0] dirty
);
  logic [NSLOT-1:0] dirty_d;
  always_ff @(posedge clk) begin
    if (rst) dirty_d <= '0;
    else     dirty_d <= dirty;
  end

  // R2: read response follows the request by one cycle
  a_r2_read_latency: assert property (@(posedge clk) disable iff (rst)
    up_rd_valid |=> rd_resp_valid);

  // R4: a writeback pulse is preceded by a cycle with no read or write
  a_r4_idle_issue: assert property (@(posedge clk) disable iff (rst)
    wb_valid |-> $past(!up_rd_valid && !up_wr_valid));

  // R6: never two writebacks back to back (one in flight)
  a_r6_single_flight: assert property (@(posedge clk) disable iff (rst)
    wb_valid |=> !wb_valid);

  // R6: the slot being copied stays changed until retired
  a_r6_flight_dirty: assert property (@(posedge clk) disable iff (rst)
    busy |-> dirty[cur_slot]);

  // R3: fill acknowledgement is a single-cycle pulse
  a_r3_fill_pulse: assert property (@(posedge clk) disable iff (rst)
    fill_ack |=> !fill_ack);

  // R9: a fill never lands on a slot holding unacknowledged changes
  a_r9_fill_clean: assert property (@(posedge clk) disable iff (rst)
    fill_ack |-> !dirty_d[fill_slot]);
endmodule

bind store_behind_ctrl sbc_checker #(.NSLOT(NSLOT)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .up_rd_valid   (up_rd_valid),
  .up_wr_valid   (up_wr_valid),
  .rd_resp_valid (rd_resp_valid),
  .wb_valid      (wb_valid),
  .fill_ack      (fill_ack),
  .fill_slot     (fill_slot),
  .busy          (trk_busy),
  .cur_slot      (trk_slot),
  .dirty         (dirty_vec)
);

// File: tb/store_behind_ctrl_bench.sv
module store_behind_ctrl_bench;
  localparam int NSLOT = 8;
  localparam int DW    = 32;
  localparam int SW    = $clog2(NSLOT);
  localparam int CW    = $clog2(NSLOT + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [CW-1:0] cfg_clean_min = '0;
  logic cfg_dual_ack = 1'b0, cfg_evict_copy = 1'b0;
  logic up_rd_valid = 1'b0, up_wr_valid = 1'b0, fill_req = 1'b0;
  logic [SW-1:0] up_rd_slot = '0, up_wr_slot = '0;
  logic [DW-1:0] up_wr_data = '0, fill_data = '0;
  logic near_ack_valid = 1'b0, far_ack_valid = 1'b0;
  logic [SW-1:0] near_ack_slot = '0, far_ack_slot = '0;
  logic rd_resp_valid, wb_valid, fill_ack;
  logic [DW-1:0] rd_resp_data, wb_data;
  logic [SW-1:0] wb_slot, fill_slot;

  always #10 clk = ~clk;  // 50 MHz

  store_behind_ctrl #(.NSLOT(NSLOT), .DW(DW)) u_store_behind_ctrl (.*);

  int checks = 0, errors = 0;
  logic [DW-1:0] model [NSLOT];
  logic [DW-1:0] exp_rd [$];
  logic [SW+DW-1:0] exp_wb [$];
  logic [SW-1:0] exp_fill [$];

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard as results appear.
  always @(negedge clk) begin
    if (!rst) begin
      if (rd_resp_valid) begin
        if (exp_rd.size() == 0) check(0, "R2 unexpected read", 64'(rd_resp_data), 0);
        else begin
          logic [DW-1:0] e;
          e = exp_rd.pop_front();
          check(rd_resp_data == e, "R2 read data", 64'(rd_resp_data), 64'(e));
        end
      end
      if (wb_valid) begin
        if (exp_wb.size() == 0) check(0, "R5 unexpected writeback", 64'({wb_slot, wb_data}), 0);
        else begin
          logic [SW+DW-1:0] e;
          e = exp_wb.pop_front();
          check({wb_slot, wb_data} == e, "R4 writeback slot/data", 64'({wb_slot, wb_data}), 64'(e));
        end
      end
      if (fill_ack) begin
        if (exp_fill.size() == 0) check(0, "R9 unexpected fill", 64'(fill_slot), 0);
        else begin
          logic [SW-1:0] e;
          e = exp_fill.pop_front();
          check(fill_slot == e, "R3 fill slot", 64'(fill_slot), 64'(e));
        end
      end
    end
  end

  task automatic tick(); @(negedge clk); #1; endtask

  task automatic do_reset(input int thr, input bit dual, input bit evict);
    rst = 1'b1; cfg_clean_min = CW'(thr); cfg_dual_ack = dual; cfg_evict_copy = evict;
    up_rd_valid = 0; up_wr_valid = 0; fill_req = 0; near_ack_valid = 0; far_ack_valid = 0;
    repeat (3) tick();
    check(wb_valid == 0 && fill_ack == 0 && rd_resp_valid == 0, "R1 outputs in reset",
          64'({wb_valid, fill_ack, rd_resp_valid}), 0);
    rst = 1'b0;
    tick();
    check(wb_valid == 0 && fill_ack == 0 && rd_resp_valid == 0, "R1 outputs after reset",
          64'({wb_valid, fill_ack, rd_resp_valid}), 0);
  endtask

  task automatic wr(input int s, input logic [DW-1:0] d);
    up_rd_valid = 0; up_wr_valid = 1; up_wr_slot = SW'(s); up_wr_data = d; model[s] = d;
    tick();
  endtask

  task automatic rd(input int s);
    up_wr_valid = 0; up_rd_valid = 1; up_rd_slot = SW'(s); exp_rd.push_back(model[s]);
    tick();
  endtask

  task automatic release_fg(); up_rd_valid = 0; up_wr_valid = 0; endtask

  task automatic push_wb(input int s); exp_wb.push_back({SW'(s), model[s]}); endtask

  task automatic wait_wb(); while (exp_wb.size() != 0) tick(); endtask

  task automatic ack_near(input int s);
    near_ack_valid = 1; near_ack_slot = SW'(s); tick(); near_ack_valid = 0;
  endtask

  task automatic ack_far(input int s);
    far_ack_valid = 1; far_ack_slot = SW'(s); tick(); far_ack_valid = 0;
  endtask

  task automatic fill_start(input int s, input logic [DW-1:0] d);
    exp_fill.push_back(SW'(s)); model[s] = d; fill_data = d; fill_req = 1;
  endtask

  task automatic fill_wait(); while (exp_fill.size() != 0) tick(); fill_req = 0; endtask

  task automatic no_wb(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      tick();
      check(wb_valid == 0, req, 64'(wb_valid), 0);
    end
  endtask

  task automatic no_fill(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      tick();
      check(fill_ack == 0, req, 64'(fill_ack), 0);
    end
  endtask

  task automatic finish_run();
    check(exp_rd.size() == 0 && exp_wb.size() == 0 && exp_fill.size() == 0,
          "R4 scoreboard drained", 64'(exp_wb.size() + exp_fill.size() + exp_rd.size()), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // ---- Phase A: store-behind, threshold 2, single acknowledgement ----
    do_reset(2, 0, 0);
    fill_start(0, 32'hF000_0000); fill_wait();           // R1: first fill to slot 0
    wr(3, 32'hA3A3_0003); wr(5, 32'hB5B5_0005);           // R2
    rd(3); release_fg();
    no_wb(6, "R5 no writeback above threshold");
    wr(0, 32'hD000_0000); wr(1, 32'hD111_1111); wr(2, 32'hD222_2222);
    wr(4, 32'hD444_4444); wr(6, 32'hD666_6666);
    push_wb(0); release_fg();                             // clean {7}: below threshold
    wait_wb();
    ack_near(4);                                          // R6: wrong slot, ignored
    fill_start(7, 32'hF777_7777); fill_wait();            // R6: slot 0 still held, fill goes to 7
    ack_near(0);                                          // clean {0,7}
    wr(7, 32'h6777_0007); push_wb(1); release_fg();       // clean {0}
    wait_wb();
    wr(1, 32'hE111_0001); release_fg();                   // R8: rewrite during copy
    push_wb(1);
    ack_near(1);
    wait_wb();                                            // R8: second copy with new data
    ack_near(1);                                          // clean {0,1}
    wr(0, 32'h4000_0000); wr(1, 32'h1111_0001);           // clean none
    push_wb(0); release_fg();
    fill_start(0, 32'hF0F0_0000);
    wait_wb();
    no_fill(4, "R9 fill waits for a clean slot");
    push_wb(1);
    ack_near(0);
    fill_wait();                                          // R9: served after acknowledgement
    wait_wb();
    ack_near(1);

    // ---- Phase B: threshold 1, dual acknowledgement; config changed after reset ----
    do_reset(1, 1, 0);
    cfg_clean_min = CW'(15); cfg_dual_ack = 0; cfg_evict_copy = 1;   // R11: must be ignored
    wr(2, 32'h2222_0002); release_fg();
    no_wb(6, "R11 post-reset config ignored");
    wr(0, 32'h0B0B_0000); wr(1, 32'h0B0B_0001); wr(3, 32'h0B0B_0003);
    wr(4, 32'h0B0B_0004); wr(5, 32'h0B0B_0005); wr(6, 32'h0B0B_0006); wr(7, 32'h0B0B_0007);
    for (int i = 0; i < 4; i++) begin
      rd((i * 3 + 2) % NSLOT);
      check(wb_valid == 0, "R4 no writeback while reading", 64'(wb_valid), 0);
    end
    push_wb(0); release_fg();
    wait_wb();
    ack_near(0);
    fill_start(0, 32'hFB00_0000);
    no_fill(4, "R7 near acknowledgement alone is not enough");
    ack_far(0);
    fill_wait();                                          // R7
    wr(0, 32'h0C0C_0000); push_wb(0); release_fg();
    wait_wb();
    ack_far(0);                                           // R7: far first
    fill_start(0, 32'hFB11_0000);
    no_fill(4, "R7 far acknowledgement alone is not enough");
    ack_near(0);
    fill_wait();

    // ---- Phase C: store-on-evict ----
    do_reset(4, 0, 1);
    for (int i = 0; i < NSLOT; i++) wr(i, 32'hC000_0000 + 32'(i));
    release_fg();
    no_wb(6, "R10 no idle writeback in evict policy");
    push_wb(0);
    fill_start(0, 32'hFC00_0000);
    wait_wb();
    no_fill(3, "R10 fill stalls until copy acknowledged");
    ack_near(0);
    fill_wait();                                          // R10
    no_wb(4, "R10 no further writeback");
    finish_run();
  end
endmodule